// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block keeps one reservation for each requester so that a load-linked / store-conditional pair on a cache line can be judged atomic. A reservation is recorded when a locked read *completes*, not when it is issued. Each reservation holds the line address and the requester that owns it.

When a store-conditional is presented, the block answers pass or fail combinationally in the same cycle, before the write is queued downstream. A pass clears the reservation and lets the write go out as an atomic request. A fail tells the requester to drop the write and report a conditional-store failure. Observed writes from other agents and line evictions clear any reservation they hit.

Two further functions sit beside the monitor:
- A small classifier maps each request kind to the request class used by the cache controller.
- A tracker holds one line blocked between a read-modify-write read completion and the matching write completion.

Top module: `llsc_monitor`

## Requirements
- R1: After reset no reservation is held and no line is blocked. A locked-read completion presented while reset is active records nothing.
- R2: A completion of kind locked read (kind code 3) on requester r and line L records a reservation (r, L). A later store-conditional from r on L gets `sc_ok`=1 in the same cycle it is presented. Completions of any other kind record nothing.
- R3: A store-conditional fails (`sc_fail`=1) when its requester holds no reservation, holds one on a different line, or when only another requester holds the line. A failing store-conditional leaves every reservation unchanged.
- R4: A passing store-conditional clears the owner's reservation and also every other requester's reservation on the same line, starting from the next cycle.
- R5: A snooped write (`snp_evict`=0) on a reserved line clears the reservations of all requesters other than the writer. The writer's own reservation is kept.
- R6: A snooped eviction (`snp_evict`=1) clears every reservation on that line, whoever owns it.
- R7: A store-conditional presented in the same cycle as a clearing snoop on its line fails.
- R8: Each requester holds at most one reservation. A new locked-read completion replaces the previous one, so a store-conditional to the old line then fails.
- R9: When a locked-read completion and a clearing event reach the same requester in the same cycle, the new reservation is kept.
- R10: `iss_class` maps kind codes as follows:
  - kind 0 (load) gives class 0;
  - kind 1 (store) gives class 1;
  - kind 2 (ifetch) gives class 2;
  - kind 3 (locked read), 4 (locked write), 5 (rmw read) and 6 (rmw write) give class 3 (atomic).
- R11: A completion of kind 5 (rmw read) on line L sets `blk_active`=1 and `blk_line`=L from the next cycle. A completion of kind 6 (rmw write) clears `blk_active` only when its line equals `blk_line`.
- R12: While `sc_valid`=1 exactly one of `sc_ok` and `sc_fail` is high. While `sc_valid`=0 both are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpl_valid | input | 1 | A request completes this cycle |
| cpl_kind | input | 3 | Kind code of the completing request |
| cpl_req | input | ID_W | Requester of the completing request |
| cpl_line | input | LINE_W | Line address of the completing request |
| snp_valid | input | 1 | An observed write or eviction this cycle |
| snp_evict | input | 1 | 1 = eviction, 0 = write by `snp_req` |
| snp_req | input | ID_W | Writer of the observed write |
| snp_line | input | LINE_W | Line address of the observed event |
| sc_valid | input | 1 | Store-conditional query |
| sc_req | input | ID_W | Requester of the query |
| sc_line | input | LINE_W | Line address of the query |
| sc_ok | output | 1 | Query passes; the write may issue |
| sc_fail | output | 1 | Query fails; drop the write |
| iss_kind | input | 3 | Kind code of a request about to issue |
| iss_class | output | 2 | Request class for the controller |
| blk_active | output | 1 | A line is blocked by an rmw pair |
| blk_line | output | LINE_W | The blocked line |

## Verification
The assertions assume the following about the inputs:
- At most one completion, one snoop and one query arrive per cycle.
- `NREQ` is a power of two, so every requester code names a real slot.
- An rmw read completion is not followed by a second one before its write completes.

The stimulus drives all inputs on the falling edge, with only one event of each kind per cycle. It issues requester codes 0 to 3 only. It uses a single read-modify-write pair at a time. Same-cycle collisions are placed deliberately: snoop against query, and completion against clear.

// File: rtl/llsc_pkg.sv
// Package: shared kind and class encodings for the reservation monitor.
// Assumes: kind codes fit in 3 bits and class codes in 2 bits.
package llsc_pkg;
    typedef enum logic [2:0] {
        K_LOAD  = 3'd0,
        K_STORE = 3'd1,
        K_FETCH = 3'd2,
        K_LLRD  = 3'd3,
        K_LLWR  = 3'd4,
        K_RMWRD = 3'd5,
        K_RMWWR = 3'd6
    } kind_e;

    typedef enum logic [1:0] {
        C_LOAD   = 2'd0,
        C_STORE  = 2'd1,
        C_FETCH  = 2'd2,
        C_ATOMIC = 2'd3
    } class_e;
endpackage

// File: rtl/llsc_slot.sv
// Module: one requester's reservation register.
// Does: records a line on set and drops it on any clearing event that hits it.
// Assumes: set has priority over clearing within the same cycle.
module llsc_slot #(
    parameter int LINE_W = 26,
    parameter int ID_W   = 2,
    parameter int MY_ID  = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set,
    input  logic [LINE_W-1:0] set_line,
    input  logic              sc_ok,
    input  logic [ID_W-1:0]   sc_req,
    input  logic [LINE_W-1:0] sc_line,
    input  logic              snp_valid,
    input  logic              snp_evict,
    input  logic [ID_W-1:0]   snp_req,
    input  logic [LINE_W-1:0] snp_line,
    output logic              rsv_valid,
    output logic [LINE_W-1:0] rsv_line
);
    localparam logic [ID_W-1:0] ME = ID_W'(MY_ID);

    logic kill;

    // Decide whether a passing conditional store or a snoop drops this reservation.
    always_comb begin
        kill = 1'b0;
        if (sc_ok && (sc_req == ME || sc_line == rsv_line))
            kill = 1'b1;
        if (snp_valid && snp_line == rsv_line && (snp_evict || snp_req != ME))
            kill = 1'b1;
    end

    // Hold the reservation: reset empties it, set wins over kill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsv_valid <= 1'b0;
            rsv_line  <= '0;
        end else if (set) begin
            rsv_valid <= 1'b1;
            rsv_line  <= set_line;
        end else if (kill) begin
            rsv_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/llsc_classify.sv
// Module: maps a request kind to the controller request class.
// Does: pure combinational translation; all locked and rmw kinds become atomic.
// Assumes: unused kind code 7 is treated as a load.
module llsc_classify (
    input  logic [2:0] kind,
    output logic [1:0] cls
);
    import llsc_pkg::*;

    // Translate one kind code into its class code.
    always_comb begin
        case (kind)
            K_STORE:                        cls = C_STORE;
            K_FETCH:                        cls = C_FETCH;
            K_LLRD, K_LLWR, K_RMWRD, K_RMWWR: cls = C_ATOMIC;
            default:                        cls = C_LOAD;
        endcase
    end
endmodule

// File: rtl/llsc_rmw_block.sv
// Module: tracks the single line held blocked during a read-modify-write pair.
// Does: rmw read completion blocks its line; matching rmw write completion unblocks.
// Assumes: only one rmw pair is open at a time.
module llsc_rmw_block #(
    parameter int LINE_W = 26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpl_valid,
    input  logic [2:0]        cpl_kind,
    input  logic [LINE_W-1:0] cpl_line,
    output logic              blk_active,
    output logic [LINE_W-1:0] blk_line
);
    import llsc_pkg::*;

    // Update the blocked-line register from rmw completions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_active <= 1'b0;
            blk_line   <= '0;
        end else if (cpl_valid && cpl_kind == K_RMWRD) begin
            blk_active <= 1'b1;
            blk_line   <= cpl_line;
        end else if (cpl_valid && cpl_kind == K_RMWWR && cpl_line == blk_line) begin
            blk_active <= 1'b0;
        end
    end
endmodule

// File: rtl/llsc_monitor.sv
// Module: load-linked / store-conditional reservation monitor (top).
// Does: one reservation per requester, same-cycle store-conditional verdict,
//       snoop clearing, request classification and rmw line blocking.
// Assumes: NREQ is a power of two; at most one completion, snoop and query per cycle.
module llsc_monitor #(
    parameter int NREQ   = 4,
    parameter int LINE_W = 26,
    localparam int ID_W  = (NREQ > 1) ? $clog2(NREQ) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpl_valid,
    input  logic [2:0]        cpl_kind,
    input  logic [ID_W-1:0]   cpl_req,
    input  logic [LINE_W-1:0] cpl_line,
    input  logic              snp_valid,
    input  logic              snp_evict,
    input  logic [ID_W-1:0]   snp_req,
    input  logic [LINE_W-1:0] snp_line,
    input  logic              sc_valid,
    input  logic [ID_W-1:0]   sc_req,
    input  logic [LINE_W-1:0] sc_line,
    output logic              sc_ok,
    output logic              sc_fail,
    input  logic [2:0]        iss_kind,
    output logic [1:0]        iss_class,
    output logic              blk_active,
    output logic [LINE_W-1:0] blk_line
);
    import llsc_pkg::*;

    logic              slot_valid [NREQ];
    logic [LINE_W-1:0] slot_line  [NREQ];
    logic              ll_done;
    logic              snp_conflict;
    logic              rsv_hit;

    assign ll_done = cpl_valid && (cpl_kind == K_LLRD);

    for (genvar i = 0; i < NREQ; i++) begin : g_slot
        llsc_slot #(.LINE_W(LINE_W), .ID_W(ID_W), .MY_ID(i)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .set       (ll_done && cpl_req == ID_W'(i)),
            .set_line  (cpl_line),
            .sc_ok     (sc_ok),
            .sc_req    (sc_req),
            .sc_line   (sc_line),
            .snp_valid (snp_valid),
            .snp_evict (snp_evict),
            .snp_req   (snp_req),
            .snp_line  (snp_line),
            .rsv_valid (slot_valid[i]),
            .rsv_line  (slot_line[i])
        );
    end

    // Judge the query against the requester's slot and any same-cycle snoop.
    always_comb begin
        snp_conflict = snp_valid && snp_line == sc_line && (snp_evict || snp_req != sc_req);
        rsv_hit      = slot_valid[sc_req] && slot_line[sc_req] == sc_line && !snp_conflict;
        sc_ok        = sc_valid && rsv_hit;
        sc_fail      = sc_valid && !rsv_hit;
    end

    llsc_classify u_cls (
        .kind (iss_kind),
        .cls  (iss_class)
    );

    llsc_rmw_block #(.LINE_W(LINE_W)) u_blk (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpl_valid  (cpl_valid),
        .cpl_kind   (cpl_kind),
        .cpl_line   (cpl_line),
        .blk_active (blk_active),
        .blk_line   (blk_line)
    );
endmodule

// File: rtl/llsc_monitor_chk.sv
// Checker: temporal properties of the reservation monitor, bound to its top.
// Assumes: the same input discipline as the monitor itself.
module llsc_monitor_chk #(
    parameter int NREQ   = 4,
    parameter int LINE_W = 26,
    localparam int ID_W  = (NREQ > 1) ? $clog2(NREQ) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpl_valid,
    input logic [2:0]        cpl_kind,
    input logic [ID_W-1:0]   cpl_req,
    input logic [LINE_W-1:0] cpl_line,
    input logic              snp_valid,
    input logic              sc_valid,
    input logic [ID_W-1:0]   sc_req,
    input logic [LINE_W-1:0] sc_line,
    input logic              sc_ok,
    input logic              sc_fail,
    input logic [2:0]        iss_kind,
    input logic [1:0]        iss_class,
    input logic              blk_active,
    input logic [LINE_W-1:0] blk_line
);
    // R12
    sc_verdict_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sc_valid |-> (sc_ok != sc_fail));

    // R12
    sc_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sc_valid |-> (!sc_ok && !sc_fail));

    // R2
    ll_then_sc_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_valid && !snp_valid && $past(rst_n) && $past(cpl_valid) && $past(cpl_kind) == 3'd3
         && $past(cpl_req) == sc_req && $past(cpl_line) == sc_line) |-> sc_ok);

    // R4
    sc_consumes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_valid && $past(rst_n) && $past(sc_ok) && $past(sc_req) == sc_req && $past(sc_line) == sc_line
         && !($past(cpl_valid) && $past(cpl_kind) == 3'd3 && $past(cpl_req) == sc_req)) |-> sc_fail);

    // R10
    atomic_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_kind >= 3'd3 && iss_kind <= 3'd6) |-> iss_class == 2'd3);

    // R11
    rmw_block_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && cpl_kind == 3'd5) |=> (blk_active && blk_line == $past(cpl_line)));
endmodule

bind llsc_monitor llsc_monitor_chk #(.NREQ(NREQ), .LINE_W(LINE_W)) u_chk (.*);

// File: tb/llsc_monitor_tb.sv
module llsc_monitor_tb;
    localparam int CLK_PERIOD = 10;
    localparam int LW = 26;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cpl_valid, snp_valid, snp_evict, sc_valid;
    logic [2:0]    cpl_kind, iss_kind;
    logic [1:0]    cpl_req, snp_req, sc_req, iss_class;
    logic [LW-1:0] cpl_line, snp_line, sc_line, blk_line;
    logic          sc_ok, sc_fail, blk_active;

    int n_run  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    llsc_monitor #(.NREQ(4), .LINE_W(LW)) u_dut (.*);

    typedef struct packed {
        logic       cv; logic [2:0] ck; logic [1:0] cr; logic [7:0] cl;
        logic       sv; logic ev; logic [1:0] sr; logic [7:0] sl;
        logic       qv; logic [1:0] qr; logic [7:0] ql;
        logic       eok; logic efail; logic [3:0] tag;
    } vec_t;

    localparam int NV = 35;
    localparam vec_t VECS [NV] = '{
        '{1,3'd3,2'd0,8'd10, 0,0,2'd0,8'd0,  0,2'd0,8'd0,   0,0,4'd2},  // R2 set r0
        '{0,3'd0,2'd0,8'd0,  0,0,2'd0,8'd0,  1,2'd0,8'd10,  1,0,4'd2},  // R2 pass
        '{0,3'd0,2'd0,8'd0,  0,0,2'd0,8'd0,  1,2'd0,8'd10,  0,1,4'd4},  // R4 consumed
        '{1,3'd3,2'd1,8'd20, 0,0,2'd0,8'd0,  0,2'd0,8'd0,   0,0,4'd2},
        '{1,3'd3,2'd2,8'd20, 0,0,2'd0,8'd0,  0,2'd0,8'd0,   0,0,4'd2},
        '{0,3'd0,2'd0,8'd0,  0,0,2'd0,8'd0,  1,2'd1,8'd20,  1,0,4'd2},
        '{0,3'd0,2'd0,8'd0,  0,0,2'd0,8'd0,  1,2'd2,8'd20,  0,1,4'd4},  // R4 peer cleared
        '{1,3'd3,2'd3,8'd30, 0,0,2'd0,8'd0,  0,2'd0,8'd0,   0,0,4'd3},
        '{0,3'd0,2'd0,8'd0,  0,0,2'd0,8'd0,  1,2'd0,8'd30,  0,1,4'd3},  // R3 other owner
        '{0,3'd0,2'd0,8'd0,  0,0,2'd0,8'd0,  1,2'd3,8'd31,  0,1,4'd3},  // R3 wrong line
        '{0,3'd0,2'd0,8'd0,  0,0,2'd0,8'd0,  1,2'd3,8'd30,  1,0,4'd3},  // R3 untouched
        '{1,3'd3,2'd0,8'd40, 0,0,2'd0,8'd0,  0,2'd0,8'd0,   0,0,4'd5},
        '{0,3'd0,2'd0,8'd0,  1,0,2'd0,8'd40, 0,2'd0,8'd0,   0,0,4'd5},  // R5 own write
        '{0,3'd0,2'd0,8'd0,  0,0,2'd0,8'd0,  1,2'd0,8'd40,  1,0,4'd5},
        '{1,3'd3,2'd1,8'd50, 0,0,2'd0,8'd0,  0,2'd0,8'd0,   0,0,4'd5},
        '{0,3'd0,2'd0,8'd0,  1,0,2'd2,8'd50, 0,2'd0,8'd0,   0,0,4'd5},  // R5 foreign write
        '{0,3'd0,2'd0,8'd0,  0,0,2'd0,8'd0,  1,2'd1,8'd50,  0,1,4'd5},
        '{1,3'd3,2'd2,8'd60, 0,0,2'd0,8'd0,  0,2'd0,8'd0,   0,0,4'd6},
        '{0,3'd0,2'd0,8'd0,  1,1,2'd2,8'd60, 0,2'd0,8'd0,   0,0,4'd6},  // R6 evict
        '{0,3'd0,2'd0,8'd0,  0,0,2'd0,8'd0,  1,2'd2,8'd60,  0,1,4'd6},
        '{1,3'd3,2'd3,8'd70, 0,0,2'd0,8'd0,  0,2'd0,8'd0,   0,0,4'd7},
        '{0,3'd0,2'd0,8'd0,  1,0,2'd1,8'd70, 1,2'd3,8'd70,  0,1,4'd7},  // R7 collision
        '{0,3'd0,2'd0,8'd0,  0,0,2'd0,8'd0,  1,2'd3,8'd70,  0,1,4'd7},
        '{1,3'd3,2'd0,8'd80, 0,0,2'd0,8'd0,  0,2'd0,8'd0,   0,0,4'd8},
        '{1,3'd3,2'd0,8'd81, 0,0,2'd0,8'd0,  0,2'd0,8'd0,   0,0,4'd8},
        '{0,3'd0,2'd0,8'd0,  0,0,2'd0,8'd0,  1,2'd0,8'd80,  0,1,4'd8},  // R8 old line
        '{0,3'd0,2'd0,8'd0,  0,0,2'd0,8'd0,  1,2'd0,8'd81,  1,0,4'd8},  // R8 new line
        '{1,3'd3,2'd1,8'd90, 0,0,2'd0,8'd0,  0,2'd0,8'd0,   0,0,4'd9},
        '{1,3'd3,2'd1,8'd91, 1,0,2'd2,8'd91, 0,2'd0,8'd0,   0,0,4'd9},  // R9 set vs snoop
        '{0,3'd0,2'd0,8'd0,  0,0,2'd0,8'd0,  1,2'd1,8'd91,  1,0,4'd9},
        '{1,3'd3,2'd2,8'd110,0,0,2'd0,8'd0,  0,2'd0,8'd0,   0,0,4'd9},
        '{1,3'd3,2'd2,8'd111,0,0,2'd0,8'd0,  1,2'd2,8'd110, 1,0,4'd9},  // R9 set vs sc clear
        '{0,3'd0,2'd0,8'd0,  0,0,2'd0,8'd0,  1,2'd2,8'd111, 1,0,4'd9},
        '{1,3'd0,2'd3,8'd120,0,0,2'd0,8'd0,  0,2'd0,8'd0,   0,0,4'd2},  // R2 plain load
        '{0,3'd0,2'd0,8'd0,  0,0,2'd0,8'd0,  1,2'd3,8'd120, 0,1,4'd2}
    };

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle();
        cpl_valid = 0; cpl_kind = 0; cpl_req = 0; cpl_line = '0;
        snp_valid = 0; snp_evict = 0; snp_req = 0; snp_line = '0;
        sc_valid = 0; sc_req = 0; sc_line = '0; iss_kind = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        idle();
        rst_n = 0;
        // R1: locked-read completion during reset must not stick
        @(negedge clk);
        cpl_valid = 1; cpl_kind = 3'd3; cpl_req = 2'd0; cpl_line = LW'(5);
        repeat (3) @(negedge clk);
        idle();
        rst_n = 1;
        #1;
        check("R1 blk_active", blk_active, 0);
        sc_valid = 1; sc_req = 2'd0; sc_line = LW'(5);
        #1;
        check("R1 sc_fail", sc_fail, 1);
        check("R1 sc_ok", sc_ok, 0);
        @(negedge clk);
        idle();

        // vector table walk
        for (int i = 0; i < NV; i++) begin
            cpl_valid = VECS[i].cv; cpl_kind = VECS[i].ck; cpl_req = VECS[i].cr; cpl_line = LW'(VECS[i].cl);
            snp_valid = VECS[i].sv; snp_evict = VECS[i].ev; snp_req = VECS[i].sr; snp_line = LW'(VECS[i].sl);
            sc_valid = VECS[i].qv; sc_req = VECS[i].qr; sc_line = LW'(VECS[i].ql);
            #1;
            check($sformatf("R%0d vec%0d sc_ok", VECS[i].tag, i), sc_ok, VECS[i].eok);
            check($sformatf("R%0d vec%0d sc_fail", VECS[i].tag, i), sc_fail, VECS[i].efail);
            if (!VECS[i].qv)
                check($sformatf("R12 vec%0d quiet", i), sc_ok | sc_fail, 0);
            @(negedge clk);
        end
        idle();

        // R10: class mapping over all kinds
        for (int k = 0; k < 7; k++) begin
            iss_kind = 3'(k);
            #1;
            check($sformatf("R10 kind%0d", k), iss_class, (k >= 3) ? 3 : k);
        end
        idle();

        // R11: rmw block and unblock
        @(negedge clk);
        cpl_valid = 1; cpl_kind = 3'd5; cpl_line = LW'(7);
        @(negedge clk);
        idle();
        check("R11 blocked", blk_active, 1);
        check("R11 blk_line", int'(blk_line), 7);
        cpl_valid = 1; cpl_kind = 3'd6; cpl_line = LW'(8);
        @(negedge clk);
        idle();
        check("R11 other line keeps block", blk_active, 1);
        cpl_valid = 1; cpl_kind = 3'd6; cpl_line = LW'(7);
        @(negedge clk);
        idle();
        check("R11 unblocked", blk_active, 0);

        @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule